// File: doc/BRIEF.md
# SONET/SDH Serial Byte Aligner

This block sits behind a clock-and-data-recovery stage. It takes one recovered serial bit per bit clock and gathers the bits into bytes, most significant bit first. It presents each byte on an 8-bit bus, together with a parallel clock that runs at one eighth of the bit rate. The bus and the frame pulse only change on the bit-clock edge where the parallel clock falls.

A downstream framer drives a level-sensitive out-of-frame request. While the request is high, the block compares every 16-bit window of the serial stream against the framing pair A1 (0xF6) followed by A2 (0x28). This covers all eight bit offsets. On a match it moves the byte boundary so that the A2 byte ends a byte. It also signals the frame with a one-period pulse on the third A2 byte.

While the request is low, the boundary is frozen and no pulse is raised. A boundary move stretches one parallel clock period instead of shortening it. The byte that was being assembled on the old boundary is dropped, so no partial byte ever reaches the bus.

Top module: `sonet_byte_aligner`

## Requirements
- R1: After a bit-clock edge with rst_n low, par_data is 0x00 and par_clk and frame_pulse are 0. The boundary offset is zero, so the first byte is emitted at the 8th bit-clock edge after reset release and holds the 8 bits received from that release onward.
- R2: Each emitted byte equals the last 8 serial bits received. The earliest of them is on par_data[7] and the latest on par_data[0].
- R3: par_data and frame_pulse change only at a bit-clock edge where par_clk falls. With no boundary change, par_clk falls once every 8 bit clocks.
- R4: While oof_req is high, the byte boundary moves to the end of an A2 byte whenever a byte 0xF6 is directly followed by a byte 0x28 at any bit offset. Every later byte is emitted on the new boundary.
- R5: While oof_req is high, frame_pulse is set together with the emission of the third A2 byte of a run that began right after an A1 byte. It stays high for exactly one par_clk period.
- R6: While oof_req is low, the byte boundary is kept even when the framing pair appears at another offset, and frame_pulse is not set.
- R7: Every par_clk period, measured between falling edges, lasts 8 to 15 bit clocks. On a boundary move no partial or duplicated byte is emitted: the bus holds its previous byte until the first byte on the new boundary.
- R8: The A2 count clears on any byte that is neither A1 nor A2. An A2 byte that does not follow an A1 byte or an already counted A2 byte is not counted. A run such as A1, A2, A2, 0x01, A2, A2, A2 therefore raises no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Recovered serial bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_in | input | 1 | Recovered serial data, one bit per bit_clk |
| oof_req | input | 1 | Out-of-frame request level; high enables boundary hunting and the frame pulse |
| par_data | output | 8 | Deserialised byte, earliest bit in bit 7 |
| par_clk | output | 1 | Parallel clock at one eighth of the bit rate; falling edge marks a new byte |
| frame_pulse | output | 1 | One-period marker on the third A2 byte while oof_req is high |

## Verification
A wrong phase count or a lost relock shows at the ports within one byte time. The falling edge of par_clk then arrives at a bit position other than the one predicted from the framing pattern and the inserted slip bits, or a period falls outside 8 to 15 bit clocks. A corrupted shift window or bit order shows on the very next emitted byte, which no longer equals the last eight bits sent. A wrong A2 count shows as a missing, early or extra frame_pulse at the next frame's A2 run, which is at most one frame later. The sweep slips the stream by one to eight bits between frames, so every boundary offset is relocked in turn.

// File: rtl/sba_pkg.sv
// Package: shared constants for the serial byte aligner.
// Assumes byte-oriented SONET/SDH framing with one A1 and one A2 code.
package sba_pkg;
    localparam int          BYTE_W  = 8;
    localparam logic [7:0]  A1_CODE = 8'hF6;
    localparam logic [7:0]  A2_CODE = 8'h28;
endpackage

// File: rtl/sba_window.sv
// Module: sba_window
// Keeps the last WIN_W-1 serial bits and presents a WIN_W-bit window whose
// LSB is the bit currently on the input. Assumes one bit per clock.
module sba_window #(
    parameter int WIN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    output logic [WIN_W-1:0] win
);
    logic [WIN_W-2:0] hist_q;

    // Purpose: shift the newest bit into the history, oldest bit falls off the top.
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= {hist_q[WIN_W-3:0], din};
    end

    // Purpose: window including the bit being sampled at this edge.
    always_comb win = {hist_q, din};
endmodule

// File: rtl/sba_phase_gen.sv
// Module: sba_phase_gen
// Counts bit positions inside a byte, flags the edge that completes a byte
// and derives the divided parallel clock. A relock restarts the count so the
// next byte ends BYTE_W bits later; the clock is never cut short.
module sba_phase_gen #(
    parameter int BYTE_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic relock,
    output logic emit,
    output logic par_clk
);
    localparam int PH_W = $clog2(BYTE_W);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(BYTE_W - 1);
    localparam logic [PH_W-1:0] PH_RISE = PH_W'(BYTE_W / 2 - 1);

    logic [PH_W-1:0] ph_q;

    // Purpose: this edge completes a byte on the current boundary.
    always_comb emit = (ph_q == PH_LAST);

    // Purpose: advance the bit position, restart on byte end or relock.
    always_ff @(posedge clk) begin
        if (!rst_n)              ph_q <= '0;
        else if (emit || relock) ph_q <= '0;
        else                     ph_q <= ph_q + 1'b1;
    end

    // Purpose: parallel clock falls with each byte and rises at mid-byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                par_clk <= 1'b0;
        else if (emit)             par_clk <= 1'b0;
        else if (ph_q == PH_RISE)  par_clk <= 1'b1;
    end
endmodule

// File: rtl/sba_a2_tracker.sv
// Module: sba_a2_tracker
// Follows the framing bytes on the emitted byte stream and raises a pulse,
// aligned with the emitted byte, on the TARGET-th A2 after an A1 while the
// out-of-frame request is high. A relock counts its own A2 as the first.
module sba_a2_tracker
    import sba_pkg::*;
#(
    parameter int TARGET = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              emit,
    input  logic              relock,
    input  logic              oof,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              pulse
);
    localparam int CNT_W = $clog2(TARGET + 1);
    localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(TARGET);
    localparam logic [CNT_W-1:0] CNT_PREV = CNT_W'(TARGET - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             after_a1_q;
    logic             a2_counts;

    // Purpose: an A2 byte extends the run only after A1 or a counted A2.
    always_comb a2_counts = (byte_in == A2_CODE) && (after_a1_q || cnt_q != '0);

    // Purpose: run counter and A1 marker, updated per emitted byte or relock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            after_a1_q <= 1'b0;
        end else if (emit) begin
            if (byte_in == A1_CODE) begin
                cnt_q      <= '0;
                after_a1_q <= 1'b1;
            end else if (a2_counts) begin
                if (cnt_q != CNT_TOP) cnt_q <= cnt_q + 1'b1;
                after_a1_q <= 1'b0;
            end else begin
                cnt_q      <= '0;
                after_a1_q <= 1'b0;
            end
        end else if (relock) begin
            cnt_q      <= CNT_W'(1);
            after_a1_q <= 1'b0;
        end
    end

    // Purpose: pulse lasts exactly one byte period, gated by the request.
    always_ff @(posedge clk) begin
        if (!rst_n)    pulse <= 1'b0;
        else if (emit) pulse <= oof && a2_counts && (cnt_q == CNT_PREV);
    end
endmodule

// File: rtl/sonet_byte_aligner.sv
// Module: sonet_byte_aligner (top)
// Serial-to-parallel converter with framing-driven byte alignment.
// Assumes a clean recovered clock and data; rst_n is synchronous, active low.
// All outputs are registers in the bit clock domain and move together on the
// edge where par_clk falls.
module sonet_byte_aligner
    import sba_pkg::*;
#(
    parameter int A2_TARGET = 3
) (
    input  logic              bit_clk,
    input  logic              rst_n,
    input  logic              ser_in,
    input  logic              oof_req,
    output logic [BYTE_W-1:0] par_data,
    output logic              par_clk,
    output logic              frame_pulse
);
    localparam int WIN_W = 2 * BYTE_W;

    logic [WIN_W-1:0] win;
    logic             emit;
    logic             relock;

    sba_window #(.WIN_W(WIN_W)) u_window (
        .clk   (bit_clk),
        .rst_n (rst_n),
        .din   (ser_in),
        .win   (win)
    );

    // Purpose: framing pair ends at this bit while hunting is requested.
    always_comb relock = oof_req && (win == {A1_CODE, A2_CODE});

    sba_phase_gen #(.BYTE_W(BYTE_W)) u_phase (
        .clk     (bit_clk),
        .rst_n   (rst_n),
        .relock  (relock),
        .emit    (emit),
        .par_clk (par_clk)
    );

    sba_a2_tracker #(.TARGET(A2_TARGET)) u_track (
        .clk     (bit_clk),
        .rst_n   (rst_n),
        .emit    (emit),
        .relock  (relock),
        .oof     (oof_req),
        .byte_in (win[BYTE_W-1:0]),
        .pulse   (frame_pulse)
    );

    // Purpose: load a completed byte onto the bus, hold it otherwise.
    always_ff @(posedge bit_clk) begin
        if (!rst_n)    par_data <= '0;
        else if (emit) par_data <= win[BYTE_W-1:0];
    end
endmodule

// File: rtl/sba_checker.sv
// Module: sba_checker
// Port-level properties of the byte aligner, bound into every instance.
module sba_checker #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              oof_req,
    input logic [BYTE_W-1:0] par_data,
    input logic              par_clk,
    input logic              frame_pulse
);
    logic       pc_q;
    logic [4:0] gap_q;
    logic       fall_seen;

    // Purpose: falling edge of par_clk as seen in the current cycle.
    always_comb fall_seen = pc_q && !par_clk;

    // Purpose: remember par_clk and count bit clocks since its last fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= 1'b0;
            gap_q <= '0;
        end else begin
            pc_q <= par_clk;
            if (fall_seen)         gap_q <= 5'd1;
            else if (gap_q != '1)  gap_q <= gap_q + 1'b1;
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (par_data == '0 && !par_clk && !frame_pulse));

    assert_data_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(par_data) |-> $fell(par_clk));

    assert_pulse_with_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_pulse) |-> $fell(par_clk));

    assert_pulse_needs_oof_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_pulse) |-> $past(oof_req));

    assert_period_bounds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fall_seen |-> (gap_q >= 5'(BYTE_W) && gap_q <= 5'(2 * BYTE_W - 1)));
endmodule

bind sonet_byte_aligner sba_checker #(.BYTE_W(8)) u_chk (
    .clk         (bit_clk),
    .rst_n       (rst_n),
    .oof_req     (oof_req),
    .par_data    (par_data),
    .par_clk     (par_clk),
    .frame_pulse (frame_pulse)
);

// File: tb/sonet_byte_aligner_test.sv
module sonet_byte_aligner_test;
    localparam logic [7:0] A1 = 8'hF6;
    localparam logic [7:0] A2 = 8'h28;

    logic       bit_clk = 1'b0;
    logic       rst_n   = 1'b0;
    logic       ser_in  = 1'b0;
    logic       oof_req = 1'b0;
    logic [7:0] par_data;
    logic       par_clk;
    logic       frame_pulse;

    sonet_byte_aligner uut (
        .bit_clk     (bit_clk),
        .rst_n       (rst_n),
        .ser_in      (ser_in),
        .oof_req     (oof_req),
        .par_data    (par_data),
        .par_clk     (par_clk),
        .frame_pulse (frame_pulse)
    );

    always #10 bit_clk = ~bit_clk;

    int         checks = 0, errors = 0;
    int         bitcount = 0, exp_phase = 0, since_fall = 0, gcnt = 0;
    bit         g_prev_a1 = 0, broken = 0, done = 0;
    logic [7:0] hist = '0, last_data = '0;
    logic       last_pulse = 0, last_pc = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One serial bit: drive, let the DUT sample, then check outputs at negedge.
    task automatic step(input bit b, input bit gend, input logic [7:0] gbyte);
        bit oof_e, relock_now, pulse_now, emit_exp, fell;
        ser_in = b;
        @(posedge bit_clk);
        bitcount++; since_fall++;
        hist  = {hist[6:0], b};
        oof_e = oof_req;
        relock_now = 0; pulse_now = 0;
        if (gend) begin
            relock_now = oof_e && gbyte == A2 && g_prev_a1;
            if (gbyte == A1) begin gcnt = 0; g_prev_a1 = 1; end
            else if (gbyte == A2 && (g_prev_a1 || gcnt != 0)) begin
                pulse_now = (gcnt == 2);
                if (gcnt < 3) gcnt++;
                g_prev_a1 = 0;
            end else begin gcnt = 0; g_prev_a1 = 0; end
        end
        emit_exp = (bitcount % 8 == exp_phase);
        if (relock_now) exp_phase = bitcount % 8;
        @(negedge bit_clk);
        fell = last_pc && !par_clk;
        check(fell == emit_exp, bitcount <= 8 ? "R1" : (oof_e ? "R4" : "R6"),
              "byte boundary", fell, emit_exp);
        if (fell) begin
            check(par_data == hist, "R2", "byte content", par_data, hist);
            check(frame_pulse == (oof_e && gend && pulse_now),
                  broken ? "R8" : (oof_e ? "R5" : "R6"), "frame pulse",
                  frame_pulse, oof_e && gend && pulse_now);
            check(since_fall >= 8 && since_fall <= 15, "R7", "period",
                  since_fall, 8);
            since_fall = 0;
        end else begin
            check(par_data == last_data, "R3", "data held", par_data, last_data);
            check(frame_pulse == last_pulse, "R3", "pulse held",
                  frame_pulse, last_pulse);
        end
        last_pc = par_clk; last_data = par_data; last_pulse = frame_pulse;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) step(v[i], i == 0, v);
    endtask

    // Framing run then payload drawn from bytes that cannot mimic A1 or A2.
    task automatic send_frame(input int seed, input bit brk);
        logic [7:0] pay [5] = '{8'h00, 8'h01, 8'h02, 8'h04, 8'h08};
        broken = brk;
        for (int i = 0; i < 3; i++) send_byte(A1);
        if (brk) begin
            send_byte(A2); send_byte(A2); send_byte(8'h01);
            send_byte(A2); send_byte(A2); send_byte(A2);
        end else begin
            for (int i = 0; i < 3; i++) send_byte(A2);
        end
        broken = 0;
        for (int i = 0; i < 10; i++) send_byte(pay[(i * 3 + seed) % 5]);
    endtask

    initial begin
        repeat (4) @(negedge bit_clk);
        check(par_data == 8'h00, "R1", "reset data", par_data, 0);
        check(par_clk == 1'b0, "R1", "reset par_clk", par_clk, 0);
        check(frame_pulse == 1'b0, "R1", "reset pulse", frame_pulse, 0);
        rst_n = 1'b1;
        // Aligned from reset, hunting off: no pulse (R6).
        send_frame(0, 0);
        send_frame(1, 0);
        // Hunting on while aligned: pulse on each third A2 (R5).
        oof_req = 1'b1;
        send_frame(2, 0);
        send_frame(3, 0);
        // Interrupted A2 run: count clears, no pulse (R8).
        send_frame(4, 1);
        // Sweep every slip of 1..8 bits: frozen, then relocked (R4, R6, R7).
        for (int k = 1; k <= 8; k++) begin
            oof_req = 1'b0;
            for (int j = 0; j < k; j++) step(1'b0, 1'b0, 8'h00);
            send_frame(k, 0);
            oof_req = 1'b1;
            send_frame(k + 1, 0);
            send_frame(k + 2, 0);
        end
        oof_req = 1'b0;
        send_frame(5, 0);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule